// File: doc/BRIEF.md
# 32-to-16-bit MAC register bridge

This block lets a controller with a 32-bit register view reach the registers of a four-channel Ethernet MAC whose register data path is only 16 bits wide. Every 32-bit request is carried out as two 16-bit transfers on the MAC side. The lower half of a register lives at its base word address. The upper half lives in a second region placed a fixed number of words above the first. The bridge computes both addresses from a channel number and a register index. It runs the two transfers in order, splits write data into halves and joins read halves back into one word.

The requester raises `req_valid` for one cycle while the bridge is idle. `busy` then stays high until the cycle in which `done` pulses, and requests seen during that time are dropped. On the MAC side each half is a request/acknowledge exchange: `mac_req` stays high, with a steady address, direction and data, until `mac_ack` is sampled high. The read halves and the error flags are captured on their acknowledge cycles.

Top module: `mac16_bridge`

## Requirements
- R1: After reset `busy`, `done`, `mac_req`, `err` and `rdata` are all zero.
- R2: The first MAC transfer of an access goes to word address 0x4000 + channel*0x80 + register index.
- R3: The second MAC transfer goes to the first transfer's address plus 0x800.
- R4: Each accepted request produces exactly two MAC transfers, the lower half strictly before the upper half.
- R5: For a write, `mac_we` is 1 on both transfers; the first carries `req_wdata[15:0]` and the second `req_wdata[31:16]`.
- R6: For a read, `mac_we` is 0 on both transfers and `rdata` at `done` equals first-half data plus second-half data shifted left by 16.
- R7: `err` at `done` is the OR of the `mac_err` values returned with the two acknowledges.
- R8: A request is accepted only while `busy` is 0; a request presented while `busy` is 1 (including the `done` cycle) starts no transfer and does not alter the access in progress.
- R9: `done` is a single-cycle pulse in the cycle after the second acknowledge.
- R10: While `mac_req` is high and not yet acknowledged, `mac_addr`, `mac_we` and `mac_wdata` keep their values, for any number of wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_chan | input | CH_W (2) | MAC channel number |
| req_reg | input | REG_W (7) | Register word index inside the channel |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Access in progress; new requests are dropped |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Joined read data, valid from `done` |
| err | output | 1 | OR of both halves' error flags, valid from `done` |
| mac_req | output | 1 | MAC-side transfer request |
| mac_we | output | 1 | MAC-side write enable |
| mac_addr | output | ADDR_W (16) | MAC-side word address |
| mac_wdata | output | 16 | MAC-side write half |
| mac_ack | input | 1 | MAC-side acknowledge |
| mac_rdata | input | 16 | MAC-side read half, valid with `mac_ack` |
| mac_err | input | 1 | MAC-side error flag, valid with `mac_ack` |

## Verification
A sequencer stuck in or skipping a phase shows up within one acknowledge. The bridge then makes the wrong number of transfers, repeats the lower address instead of jumping by 0x800, or leaves `done` high or absent in the cycle after the second acknowledge. A wrong capture register becomes visible at the `done` cycle: read halves swapped or stale, or an error flag from one half lost. A request taken while busy would show as a third transfer, or as `mac_req` rising again within the few cycles after `done`. The sweep covers every channel and register index, uses acknowledge delays of zero to several cycles, and holds a competing request for the whole length of some accesses.

// File: rtl/mac16_bridge_pkg.sv
package mac16_bridge_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOW  = 2'd1,
    ST_HIGH = 2'd2,
    ST_DONE = 2'd3
  } brg_state_t;

  // word address of the lower half of a register
  function automatic logic [31:0] low_word_addr(input logic [31:0] base,
                                                input logic [31:0] stride,
                                                input logic [31:0] ch,
                                                input logic [31:0] rg);
    return base + ch * stride + rg;
  endfunction

  // word address of the upper half, a fixed distance above the lower half
  function automatic logic [31:0] high_word_addr(input logic [31:0] low,
                                                 input logic [31:0] offset);
    return low + offset;
  endfunction

  // one half of a 32-bit word
  function automatic logic [15:0] pick_half(input logic [31:0] w, input logic upper);
    return upper ? w[31:16] : w[15:0];
  endfunction

  // full word from two halves
  function automatic logic [31:0] join_halves(input logic [15:0] lo, input logic [15:0] hi);
    return {hi, lo};
  endfunction

endpackage

// File: rtl/mac16_seq.sv
module mac16_seq
  import mac16_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic mac_ack,
  output logic accept,
  output logic lo_ack,
  output logic hi_ack,
  output logic phase_hi,
  output logic mac_req,
  output logic busy,
  output logic done
);

  brg_state_t state, nxt;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (req_valid) nxt = ST_LOW;
      ST_LOW:  if (mac_ack)   nxt = ST_HIGH;
      ST_HIGH: if (mac_ack)   nxt = ST_DONE;
      ST_DONE: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  assign accept   = (state == ST_IDLE) && req_valid;
  assign lo_ack   = (state == ST_LOW)  && mac_ack;
  assign hi_ack   = (state == ST_HIGH) && mac_ack;
  assign phase_hi = (state == ST_HIGH);
  assign mac_req  = (state == ST_LOW) || (state == ST_HIGH);
  assign busy     = (state != ST_IDLE);
  assign done     = (state == ST_DONE);

endmodule

// File: rtl/mac16_addr_map.sv
module mac16_addr_map
  import mac16_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CH_W      = 2,
  parameter int unsigned REG_W     = 7,
  parameter int unsigned CH_BASE   = 32'h4000,
  parameter int unsigned CH_STRIDE = 32'h80,
  parameter int unsigned HI_OFFSET = 32'h800
) (
  input  logic [CH_W-1:0]   ch,
  input  logic [REG_W-1:0]  rg,
  input  logic              phase_hi,
  output logic [ADDR_W-1:0] addr
);

  logic [31:0] lo_full;
  logic [31:0] hi_full;

  always_comb begin
    lo_full = low_word_addr(CH_BASE, CH_STRIDE, 32'(ch), 32'(rg));
    hi_full = high_word_addr(lo_full, HI_OFFSET);
    addr    = ADDR_W'(phase_hi ? hi_full : lo_full);
  end

endmodule

// File: rtl/mac16_assemble.sv
module mac16_assemble
  import mac16_bridge_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        accept,
  input  logic [31:0] req_wdata,
  input  logic        lo_ack,
  input  logic        hi_ack,
  input  logic        phase_hi,
  input  logic [15:0] mac_rdata,
  input  logic        mac_err,
  output logic [15:0] wdata_half,
  output logic [31:0] rdata,
  output logic        err
);

  logic [31:0] wd_q;
  logic [15:0] lo_q;
  logic        err_lo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wd_q     <= '0;
      lo_q     <= '0;
      err_lo_q <= 1'b0;
      rdata    <= '0;
      err      <= 1'b0;
    end else begin
      if (accept) begin
        wd_q     <= req_wdata;
        err_lo_q <= 1'b0;
      end
      if (lo_ack) begin
        lo_q     <= mac_rdata;
        err_lo_q <= mac_err;
      end
      if (hi_ack) begin
        rdata <= join_halves(lo_q, mac_rdata);
        err   <= err_lo_q | mac_err;
      end
    end
  end

  assign wdata_half = pick_half(wd_q, phase_hi);

endmodule

// File: rtl/mac16_bridge.sv
module mac16_bridge
  import mac16_bridge_pkg::*;
#(
  parameter int unsigned NUM_CH    = 4,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned CH_BASE   = 32'h4000,
  parameter int unsigned CH_STRIDE = 32'h80,
  parameter int unsigned HI_OFFSET = 32'h800,
  localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int unsigned REG_W    = (CH_STRIDE > 1) ? $clog2(CH_STRIDE) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [CH_W-1:0]   req_chan,
  input  logic [REG_W-1:0]  req_reg,
  input  logic [31:0]       req_wdata,
  output logic              busy,
  output logic              done,
  output logic [31:0]       rdata,
  output logic              err,
  output logic              mac_req,
  output logic              mac_we,
  output logic [ADDR_W-1:0] mac_addr,
  output logic [15:0]       mac_wdata,
  input  logic              mac_ack,
  input  logic [15:0]       mac_rdata,
  input  logic              mac_err
);

  // internal events, named for the checker
  logic accept;
  logic lo_ack;
  logic hi_ack;
  logic phase_hi;

  logic [CH_W-1:0]  ch_q;
  logic [REG_W-1:0] rg_q;
  logic             we_q;

  mac16_seq u_seq (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .mac_ack  (mac_ack),
    .accept   (accept),
    .lo_ack   (lo_ack),
    .hi_ack   (hi_ack),
    .phase_hi (phase_hi),
    .mac_req  (mac_req),
    .busy     (busy),
    .done     (done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ch_q <= '0;
      rg_q <= '0;
      we_q <= 1'b0;
    end else if (accept) begin
      ch_q <= req_chan;
      rg_q <= req_reg;
      we_q <= req_write;
    end
  end

  mac16_addr_map #(
    .ADDR_W   (ADDR_W),
    .CH_W     (CH_W),
    .REG_W    (REG_W),
    .CH_BASE  (CH_BASE),
    .CH_STRIDE(CH_STRIDE),
    .HI_OFFSET(HI_OFFSET)
  ) u_map (
    .ch      (ch_q),
    .rg      (rg_q),
    .phase_hi(phase_hi),
    .addr    (mac_addr)
  );

  mac16_assemble u_asm (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .req_wdata (req_wdata),
    .lo_ack    (lo_ack),
    .hi_ack    (hi_ack),
    .phase_hi  (phase_hi),
    .mac_rdata (mac_rdata),
    .mac_err   (mac_err),
    .wdata_half(mac_wdata),
    .rdata     (rdata),
    .err       (err)
  );

  assign mac_we = we_q;

endmodule

// File: rtl/mac16_bridge_chk.sv
module mac16_bridge_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned HI_OFFSET = 32'h800
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              busy,
  input logic              done,
  input logic              mac_req,
  input logic              mac_we,
  input logic [ADDR_W-1:0] mac_addr,
  input logic [15:0]       mac_wdata,
  input logic              mac_ack,
  input logic              phase_hi
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!busy && !done && !mac_req));

  // R3 / R4: lower-half handshake is followed by the upper half, 0x800 higher
  assert_hi_follows_lo_R3: assert property (@(posedge clk) disable iff (rst)
    (mac_req && mac_ack && !phase_hi) |=>
      (mac_req && phase_hi && (mac_addr == $past(mac_addr) + ADDR_W'(HI_OFFSET))));

  assert_start_only_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mac_req) |-> ($past(req_valid) && !$past(busy)));

  assert_done_after_hi_R9: assert property (@(posedge clk) disable iff (rst)
    (mac_req && mac_ack && phase_hi) |=> done);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (rst)
    (mac_req && !mac_ack) |=>
      (mac_req && $stable(mac_addr) && $stable(mac_we) && $stable(mac_wdata)));

endmodule

bind mac16_bridge mac16_bridge_chk #(
  .ADDR_W   (ADDR_W),
  .HI_OFFSET(HI_OFFSET)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .mac_req  (mac_req),
  .mac_we   (mac_we),
  .mac_addr (mac_addr),
  .mac_wdata(mac_wdata),
  .mac_ack  (mac_ack),
  .phase_hi (phase_hi)
);

// File: tb/mac16_bridge_test.sv
module mac16_bridge_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [1:0]  req_chan = '0;
  logic [6:0]  req_reg = '0;
  logic [31:0] req_wdata = '0;
  logic        busy, done, err, mac_req, mac_we;
  logic [31:0] rdata;
  logic [15:0] mac_addr, mac_wdata;
  logic        mac_ack = 1'b0;
  logic [15:0] mac_rdata = '0;
  logic        mac_err = 1'b0;

  always #5 clk = ~clk;

  mac16_bridge uut (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_chan(req_chan),
    .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .err(err),
    .mac_req(mac_req), .mac_we(mac_we), .mac_addr(mac_addr), .mac_wdata(mac_wdata),
    .mac_ack(mac_ack), .mac_rdata(mac_rdata), .mac_err(mac_err)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // MAC responder state and transfer log
  int          wait_cycles = 0;
  int          wcnt = 0;
  logic [15:0] bad_addr = 16'hFFFF;
  logic [15:0] log_addr [0:7];
  logic [15:0] log_data [0:7];
  logic        log_we   [0:7];
  int          log_n = 0;
  int          stab_err = 0;
  logic [15:0] seen_a, seen_d;

  function automatic logic [15:0] mac_model(input logic [15:0] a);
    return 16'(a * 16'h9E37) ^ 16'h5A5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mac_ack) begin
        mac_ack = 1'b0;
        mac_err = 1'b0;
        wcnt = 0;
      end else if (!rst && mac_req) begin
        if (wcnt == 0) begin
          seen_a = mac_addr;
          seen_d = mac_wdata;
        end else if (mac_addr != seen_a || mac_wdata != seen_d) begin
          stab_err++;
        end
        if (wcnt >= wait_cycles) begin
          if (log_n < 8) begin
            log_addr[log_n] = mac_addr;
            log_data[log_n] = mac_wdata;
            log_we[log_n]   = mac_we;
          end
          log_n++;
          mac_rdata = mac_model(mac_addr);
          mac_err   = (mac_addr == bad_addr);
          mac_ack   = 1'b1;
        end else begin
          wcnt++;
        end
      end else begin
        wcnt = 0;
      end
    end
  end

  task automatic do_access(input bit we, input int ch, input int rg,
                           input logic [31:0] wd, input bit jam);
    logic [15:0] lo_e, hi_e;
    logic [31:0] rd_e;
    bit          err_e;
    bit          seen_done;
    lo_e  = 16'(32'h4000 + (ch << 7) + rg);
    hi_e  = 16'(32'h4800 + ch * 128 + rg);
    rd_e  = (32'(mac_model(hi_e)) << 16) + 32'(mac_model(lo_e));
    err_e = (lo_e == bad_addr) || (hi_e == bad_addr);
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_chan = 2'(ch); req_reg = 7'(rg); req_wdata = wd;
    seen_done = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (jam) begin
        // competing request held while busy (R8)
        req_valid = 1'b1; req_write = ~we; req_chan = 2'(ch + 1);
        req_reg = 7'(rg ^ 5); req_wdata = ~wd;
      end else begin
        req_valid = 1'b0;
      end
      if (done) begin
        seen_done = 1;
        break;
      end
    end
    req_valid = 1'b0;
    chk(seen_done, "R9 done seen", 32'(seen_done), 1);
    chk(log_n == 2, "R4 transfer count", 32'(log_n), 2);
    chk(log_addr[0] == lo_e, "R2 low address", 32'(log_addr[0]), 32'(lo_e));
    chk(log_addr[1] == hi_e, "R3 high address", 32'(log_addr[1]), 32'(hi_e));
    chk(log_we[0] == we && log_we[1] == we, we ? "R5 write enable" : "R6 read enable",
        {30'd0, log_we[1], log_we[0]}, {30'd0, we, we});
    if (we) begin
      chk(log_data[0] == wd[15:0], "R5 first half data", 32'(log_data[0]), 32'(wd[15:0]));
      chk(log_data[1] == wd[31:16], "R5 second half data", 32'(log_data[1]), 32'(wd[31:16]));
    end else begin
      chk(rdata == rd_e, "R6 joined read data", rdata, rd_e);
    end
    chk(err == err_e, "R7 error OR", 32'(err), 32'(err_e));
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (k == 0) chk(!done, "R9 done single cycle", 32'(done), 0);
      chk(!mac_req && log_n == 2, "R8 no extra transfer", 32'(log_n), 2);
    end
    chk(stab_err == 0, "R10 held until ack", 32'(stab_err), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mac_req && !err && rdata == 0, "R1 reset state",
        {rdata[27:0], busy, done, mac_req, err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !mac_req, "R1 idle after reset", {30'd0, busy, mac_req}, 0);

    // near-exhaustive sweep over every channel and register index
    for (int ch = 0; ch < 4; ch++) begin
      for (int rg = 0; rg < 128; rg++) begin
        wait_cycles = rg % 4;
        do_access(1'b0, ch, rg, 32'h0, (rg % 5) == 0);
        do_access(1'b1, ch, rg,
                  {8'(ch * 17), 8'(rg), ~8'(rg), 8'(ch + rg)}, (rg % 7) == 3);
      end
    end

    // error flag from either half, long waits (R7, R10)
    wait_cycles = 6;
    bad_addr = 16'h4185;
    do_access(1'b0, 3, 5, 32'h0, 1'b0);
    bad_addr = 16'h4985;
    do_access(1'b0, 3, 5, 32'h0, 1'b1);
    do_access(1'b1, 3, 5, 32'hDEAD_BEEF, 1'b0);
    bad_addr = 16'hFFFF;
    do_access(1'b0, 3, 5, 32'h0, 1'b0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule